// File: doc/BRIEF.md
# Privileged status register with interrupt acceptance

This block keeps a 16-bit processor status word and decides when a pending interrupt is taken. The upper byte is the system byte. It holds a trace enable, a supervisor/user flag, a master/interrupt flag and a 3-bit priority mask. The lower byte holds the condition codes. Software writes reach the register tagged with the privilege they were issued under. A user-mode write can only touch the condition codes. An execution unit can refresh the condition codes on its own strobe.

A 3-bit pending level is compared against the mask, and the block raises a combinational accept when the request is admitted. Level 7 is the exception: it is admitted only on its rising edge, and no mask value can hold it back. The accept takes effect at the same clock edge. At that edge the system byte switches to supervisor mode, clears trace and master, and loads the mask with the level that was taken. A registered trace request follows every instruction-complete strobe while trace is on.

Top module: `psr_irq_unit`

## Requirements
- R1: The status word is laid out as trace at bit 15, supervisor at bit 13, master at bit 12, mask at bits 10:8 and condition codes at bits 7:0. Bits 14 and 11 always read 0.
- R2: A synchronous active-high reset sets bits 15:8 to 0x27: supervisor, trace off, master clear, mask 7. It also holds `irq_take` and `trace_req` low. The condition-code byte after reset is not specified.
- R3: A write with `wr_sup`=1 loads bits 15:8 from `wr_data` with bits 14 and 11 forced to 0, and loads bits 7:0 from `wr_data`.
- R4: A write with `wr_sup`=0 loads only bits 7:0 and leaves bits 15:8 unchanged.
- R5: `cc_we` loads `cc_in` into bits 7:0 on its own. An accepted software write in the same cycle wins over it.
- R6: Levels 1 to 6 are accepted exactly when the level is greater than the mask. Level 0 is never accepted.
- R7: Level 7 is accepted on a 0-to-1 change of (level==7), whatever the mask. Holding level 7 never gives a second accept. After reset the level must be seen below 7 for at least one cycle before an edge counts.
- R8: At the edge where `irq_take` is high, the system byte becomes trace 0, supervisor 1, master 0 and mask = the accepted level. A software write in that cycle is discarded whole.
- R9: `trace_req` is high for one cycle, one cycle after an `instr_done` that arrives while trace is set. Otherwise it is low.
- R10: A supervisor write can set the master bit and can clear the supervisor bit, entering user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_sup | input | 1 | Privilege of the write (1 = supervisor) |
| wr_data | input | 16 | Write value |
| cc_we | input | 1 | Condition-code update strobe from the execution unit |
| cc_in | input | 8 | New condition codes |
| irq_level | input | 3 | Pending interrupt level, 0 = none |
| instr_done | input | 1 | Instruction-complete strobe |
| irq_take | output | 1 | Interrupt accepted this cycle (combinational) |
| trace_req | output | 1 | Trace request pulse |
| sr | output | 16 | Current status word |

## Verification
The bench targets the equal-to-mask case. A design using >= there would take a level-3 request under mask 3. It holds level 7 across a supervisor write that drops the mask to 0. A design that compares level 7 against the mask would then accept a second time. It collides a supervisor write with an accept, and a user write with a condition-code strobe: a wrong priority shows up as a stray system byte or stray flags. It also checks that a level 7 held through reset is not taken, and that a trace strobe arriving in the same cycle as an accept still uses the old trace bit.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int LVL_W  = 3;
    localparam int CCR_W  = 8;
    localparam int SYS_W  = 8;
    localparam logic [SYS_W-1:0] SYS_RESET = 8'h27;
    localparam logic [SYS_W-1:0] SYS_WMASK = 8'hB7;   // bits 14 and 11 hard zero
    localparam logic [LVL_W-1:0] TOP_LVL   = '1;

    typedef struct packed {
        logic             trc;
        logic             rsv_a;
        logic             sup;
        logic             mst;
        logic             rsv_b;
        logic [LVL_W-1:0] mask;
    } sys_byte_t;

    typedef struct packed {
        sys_byte_t        sys;
        logic [CCR_W-1:0] ccr;
    } status_t;

    function automatic sys_byte_t sys_from_bus(input logic [SYS_W-1:0] b);
        return sys_byte_t'(b & SYS_WMASK);
    endfunction

    function automatic sys_byte_t sys_on_accept(input sys_byte_t cur,
                                                input logic [LVL_W-1:0] lvl);
        sys_byte_t n;
        n      = cur;
        n.trc  = 1'b0;
        n.sup  = 1'b1;
        n.mst  = 1'b0;
        n.mask = lvl;
        return n;
    endfunction
endpackage

// File: rtl/psr_irq_gate.sv
module psr_irq_gate
    import psr_pkg::*;
#(
    parameter int LW = LVL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] mask,
    output logic          take
);
    localparam logic [LW-1:0] NMI_LVL = '1;

    logic top_now;
    logic top_prev;
    logic top_rise;
    logic masked_ok;

    assign top_now   = (level == NMI_LVL);
    assign top_rise  = top_now && !top_prev;
    assign masked_ok = (level != '0) && !top_now && (level > mask);
    assign take      = !rst && (masked_ok || top_rise);

    // Treat the top level as already high while in reset: a fresh edge is needed.
    always_ff @(posedge clk) begin
        if (rst) top_prev <= 1'b1;
        else     top_prev <= top_now;
    end

    p_idle_no_take_r6: assert property (@(posedge clk) disable iff (rst)
        (level == '0) |-> !take);
    p_mask_block_r6: assert property (@(posedge clk) disable iff (rst)
        ((level != NMI_LVL) && (level <= mask)) |-> !take);
    p_top_held_r7: assert property (@(posedge clk) disable iff (rst)
        ((level == NMI_LVL) && $past(level == NMI_LVL)) |-> !take);
endmodule

// File: rtl/psr_trace_gen.sv
module psr_trace_gen (
    input  logic clk,
    input  logic rst,
    input  logic trc_on,
    input  logic done,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= done && trc_on;
    end

    p_trace_follow_r9: assert property (@(posedge clk) disable iff (rst)
        (done && trc_on) |=> req);
    p_trace_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !(done && trc_on) |=> !req);
endmodule

// File: rtl/psr_irq_unit.sv
module psr_irq_unit
    import psr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   wr_sup,
    input  logic [SYS_W+CCR_W-1:0] wr_data,
    input  logic                   cc_we,
    input  logic [CCR_W-1:0]       cc_in,
    input  logic [LVL_W-1:0]       irq_level,
    input  logic                   instr_done,
    output logic                   irq_take,
    output logic                   trace_req,
    output logic [SYS_W+CCR_W-1:0] sr
);
    status_t cur;
    status_t nxt;

    psr_irq_gate #(.LW(LVL_W)) u_gate (
        .clk   (clk),
        .rst   (rst),
        .level (irq_level),
        .mask  (cur.sys.mask),
        .take  (irq_take)
    );

    psr_trace_gen u_trace (
        .clk    (clk),
        .rst    (rst),
        .trc_on (cur.sys.trc),
        .done   (instr_done),
        .req    (trace_req)
    );

    // Priority: accept > software write > condition-code strobe.
    always_comb begin
        nxt = cur;
        if (cc_we) nxt.ccr = cc_in;
        if (wr_en && !irq_take) begin
            nxt.ccr = wr_data[CCR_W-1:0];
            if (wr_sup) nxt.sys = sys_from_bus(wr_data[SYS_W+CCR_W-1:CCR_W]);
        end
        if (irq_take) nxt.sys = sys_on_accept(cur.sys, irq_level);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.sys <= sys_byte_t'(SYS_RESET);
            cur.ccr <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign sr = cur;

    p_rsv_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (sr[14] == 1'b0) && (sr[11] == 1'b0));
    p_user_sys_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sup && !irq_take) |=> $stable(sr[15:8]));
    p_sup_write_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sup && !irq_take) |=>
            (sr == {$past(wr_data[15:8]) & 8'hB7, $past(wr_data[7:0])}));
    p_take_update_r8: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> (sr[15] == 1'b0 && sr[13] == 1'b1 && sr[12] == 1'b0
                      && sr[10:8] == $past(irq_level)));
endmodule

// File: tb/tb_psr_irq_unit.sv
module tb_psr_irq_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_sup = 1'b0, cc_we = 1'b0, instr_done = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  cc_in = '0;
    logic [2:0]  irq_level = '0;
    logic        irq_take, trace_req;
    logic [15:0] sr;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    psr_irq_unit dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sup(wr_sup), .wr_data(wr_data),
        .cc_we(cc_we), .cc_in(cc_in), .irq_level(irq_level),
        .instr_done(instr_done), .irq_take(irq_take), .trace_req(trace_req), .sr(sr)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        wen;
        logic        sup;
        logic [15:0] wdata;
        logic        ccwe;
        logic [7:0]  ccin;
        logic [2:0]  lvl;
        logic        done;
        logic        etake;
        logic [15:0] esr;
        logic        etrc;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{4'd2,  1'b0,1'b0,16'h0000, 1'b0,8'h00, 3'd0,1'b0, 1'b0,16'h2700,1'b0}, // R2 idle
        '{4'd4,  1'b1,1'b0,16'hFFAA, 1'b0,8'h00, 3'd0,1'b0, 1'b0,16'h27AA,1'b0}, // R4 user write
        '{4'd3,  1'b1,1'b1,16'hFFFF, 1'b0,8'h00, 3'd0,1'b0, 1'b0,16'hB7FF,1'b0}, // R3 R1 sup write
        '{4'd9,  1'b0,1'b0,16'h0000, 1'b0,8'h00, 3'd0,1'b1, 1'b0,16'hB7FF,1'b1}, // R9 trace on
        '{4'd3,  1'b1,1'b1,16'h2055, 1'b0,8'h00, 3'd0,1'b0, 1'b0,16'h2055,1'b0}, // R3 mask 0
        '{4'd8,  1'b0,1'b0,16'h0000, 1'b0,8'h00, 3'd3,1'b0, 1'b1,16'h2355,1'b0}, // R8 R6 take 3
        '{4'd6,  1'b0,1'b0,16'h0000, 1'b0,8'h00, 3'd3,1'b0, 1'b0,16'h2355,1'b0}, // R6 equal blocked
        '{4'd6,  1'b0,1'b0,16'h0000, 1'b0,8'h00, 3'd2,1'b0, 1'b0,16'h2355,1'b0}, // R6 below blocked
        '{4'd8,  1'b1,1'b1,16'h0000, 1'b0,8'h00, 3'd4,1'b0, 1'b1,16'h2455,1'b0}, // R8 write dropped
        '{4'd5,  1'b0,1'b0,16'h0000, 1'b1,8'h11, 3'd0,1'b0, 1'b0,16'h2411,1'b0}, // R5 cc strobe
        '{4'd5,  1'b1,1'b0,16'h00EE, 1'b1,8'h22, 3'd0,1'b0, 1'b0,16'h24EE,1'b0}, // R5 write wins
        '{4'd7,  1'b0,1'b0,16'h0000, 1'b0,8'h00, 3'd7,1'b0, 1'b1,16'h27EE,1'b0}, // R7 edge
        '{4'd7,  1'b0,1'b0,16'h0000, 1'b0,8'h00, 3'd7,1'b0, 1'b0,16'h27EE,1'b0}, // R7 held
        '{4'd10, 1'b1,1'b1,16'h1000, 1'b0,8'h00, 3'd7,1'b0, 1'b0,16'h1000,1'b0}, // R10 R7 held mask0
        '{4'd6,  1'b0,1'b0,16'h0000, 1'b0,8'h00, 3'd0,1'b0, 1'b0,16'h1000,1'b0}, // R6 level 0
        '{4'd7,  1'b0,1'b0,16'h0000, 1'b0,8'h00, 3'd7,1'b0, 1'b1,16'h2700,1'b0}, // R7 re-edge
        '{4'd9,  1'b0,1'b0,16'h0000, 1'b0,8'h00, 3'd0,1'b1, 1'b0,16'h2700,1'b0}, // R9 trace off
        '{4'd6,  1'b0,1'b0,16'h0000, 1'b0,8'h00, 3'd6,1'b0, 1'b0,16'h2700,1'b0}, // R6 6 under 7
        '{4'd10, 1'b1,1'b1,16'h8000, 1'b0,8'h00, 3'd0,1'b0, 1'b0,16'h8000,1'b0}, // R10 user mode
        '{4'd9,  1'b0,1'b0,16'h0000, 1'b0,8'h00, 3'd5,1'b1, 1'b1,16'h2500,1'b1}, // R9 R8 both
        '{4'd4,  1'b1,1'b0,16'hFF33, 1'b0,8'h00, 3'd0,1'b0, 1'b0,16'h2533,1'b0}  // R4 user tag
    };

    task automatic chk(input int req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_in();
        wr_en = 0; wr_sup = 0; wr_data = '0; cc_we = 0; cc_in = '0; instr_done = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R2: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(2, "reset sys byte", {8'h0, sr[15:8]}, 16'h0027);
        chk(2, "reset take", {15'h0, irq_take}, 16'h0);
        chk(2, "reset trace", {15'h0, trace_req}, 16'h0);
        rst = 0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VEC[i].wen; wr_sup = VEC[i].sup; wr_data = VEC[i].wdata;
            cc_we = VEC[i].ccwe; cc_in = VEC[i].ccin;
            irq_level = VEC[i].lvl; instr_done = VEC[i].done;
            #1;
            chk(VEC[i].req, $sformatf("vec %0d take", i), {15'h0, irq_take}, {15'h0, VEC[i].etake});
            @(posedge clk); #1;
            chk(VEC[i].req, $sformatf("vec %0d sr", i), sr, VEC[i].esr);
            chk(VEC[i].req, $sformatf("vec %0d trace", i), {15'h0, trace_req}, {15'h0, VEC[i].etrc});
        end

        // R2 R7: level 7 held through reset is not an edge
        @(negedge clk);
        idle_in(); irq_level = 3'd7; rst = 1;
        @(posedge clk); @(posedge clk); #1;
        chk(2, "reset again sys", {8'h0, sr[15:8]}, 16'h0027);
        chk(2, "take low in reset", {15'h0, irq_take}, 16'h0);
        @(negedge clk); rst = 0;
        #1;
        chk(7, "held 7 after reset", {15'h0, irq_take}, 16'h0);
        @(negedge clk); irq_level = 3'd0;
        @(negedge clk); irq_level = 3'd7; #1;
        chk(7, "fresh edge after reset", {15'h0, irq_take}, 16'h1);
        @(posedge clk); #1;
        chk(8, "sys after top take", {8'h0, sr[15:8]}, 16'h0027);

        // R1: reserved bits after writing ones
        @(negedge clk); irq_level = 3'd0; wr_en = 1; wr_sup = 1; wr_data = 16'h4800;
        @(posedge clk); #1;
        chk(1, "reserved bits zero", sr & 16'h4800, 16'h0000);
        @(negedge clk); idle_in();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule